// File: doc/BRIEF.md
# Twin-Snapshot Page Diff Writeback Engine

This block lets several nodes write the same shared page at once. When a page is loaded into the local working memory for writing, each loaded word goes to a twin snapshot as well as to the working copy. Local stores between acquire and release change only the working copy and send nothing. On a release, the engine walks the page in ascending word order, one index per clock. It compares the working copy with the twin and streams out only the words that differ, as one merged message. Each beat carries the word index and the new data, and the final beat is flagged.

At the home node, a matching apply port writes each received word into the home copy at its index. It pulses a done flag after the final beat. Diffs from different writers that touch disjoint words therefore combine into one correct home page. The page is a small on-chip memory of 64 words of 32 bits.

Top module: `twin_diff_engine`

## Requirements
- R1: After reset, the working copy, the twin and the home copy read as zero, `rel_busy` is 0, `wr_ready` is 1 and `dv_valid` is 0.
- R2: A load beat accepted while idle writes the same word into both the working copy and the twin, so a release right after a load finds no changed words.
- R3: Local writes change only the working copy and cause no beat on the diff stream before a release.
- R4: During a release, each changed word is sent as one beat holding its index (`dv_idx`) and the working data (`dv_data`), in strictly ascending index order.
- R5: A word whose working value equals its twin value is not sent, even if it was written.
- R6: `dv_last` is 1 only on the beat of the highest changed index, and `dv_empty` is 0 on every data beat.
- R7: A release with no changed words emits exactly one beat with `dv_last`=1, `dv_empty`=1, `dv_idx`=0 and `dv_data`=0.
- R8: While `dv_valid` is 1 and `dv_ready` is 0, the beat's index, data and flags stay unchanged.
- R9: While `rel_busy` is 1, `wr_ready` is 0 and any local write or load is ignored.
- R10: When a release completes, the twin equals the working copy, so an immediate second release is empty.
- R11: The apply port writes `ap_data` at `ap_idx` for each beat with `ap_valid`=1 and `ap_empty`=0. It raises `ap_done` for exactly the one cycle after a beat with `ap_last`=1.
- R12: Diffs from two writers that touch disjoint words both end up in the home copy, and untouched home words keep their old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Page load beat (writes working copy and twin) |
| ld_idx | input | 6 | Load word index |
| ld_data | input | 32 | Load word data |
| wr_valid | input | 1 | Local write to working copy |
| wr_idx | input | 6 | Local write index |
| wr_data | input | 32 | Local write data |
| wr_ready | output | 1 | Local writes and loads accepted |
| rel_req | input | 1 | Release request pulse |
| rel_busy | output | 1 | Release scan in progress |
| dv_valid | output | 1 | Diff beat valid |
| dv_ready | input | 1 | Diff sink ready |
| dv_idx | output | 6 | Diff word index |
| dv_data | output | 32 | Diff word data |
| dv_last | output | 1 | Final beat of the message |
| dv_empty | output | 1 | Message carries no words |
| ap_valid | input | 1 | Incoming diff beat at home |
| ap_idx | input | 6 | Incoming word index |
| ap_data | input | 32 | Incoming word data |
| ap_last | input | 1 | Incoming final beat |
| ap_empty | input | 1 | Incoming empty message |
| ap_done | output | 1 | One-cycle pulse after final beat applied |
| hm_idx | input | 6 | Home copy read index |
| hm_data | output | 32 | Home copy read data |

## Verification
The assertions assume that `dv_ready` and the apply inputs are clean 0/1 values each cycle. They also assume the sink follows the usual valid/ready rule, so a beat is consumed only on a cycle where both are high. The bench drives every input at the falling edge, so no input changes near the active edge. It also forms the apply beats from accepted diff beats, or from a scripted second writer whose beats it presents one at a time. A ready pattern that toggles exercises the hold rule, and a write attempted during a scan confirms that such writes are ignored.

// File: rtl/tdw_pkg.sv
package tdw_pkg;
    localparam int unsigned PAGE_WORDS = 64;
    localparam int unsigned WORD_BITS  = 32;
    localparam int unsigned IDX_BITS   = $clog2(PAGE_WORDS);

    typedef enum logic [1:0] {
        SC_IDLE  = 2'd0,
        SC_SCAN  = 2'd1,
        SC_EMPTY = 2'd2
    } scan_st_e;
endpackage

// File: rtl/tdw_page_store.sv
module tdw_page_store #(
    parameter int unsigned WORDS = tdw_pkg::PAGE_WORDS,
    parameter int unsigned DW    = tdw_pkg::WORD_BITS,
    localparam int unsigned IW   = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_busy,
    input  logic             ld_valid,
    input  logic [IW-1:0]    ld_idx,
    input  logic [DW-1:0]    ld_data,
    input  logic             wr_valid,
    input  logic [IW-1:0]    wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic             twin_we,
    input  logic [IW-1:0]    scan_idx,
    output logic [DW-1:0]    scan_data,
    output logic [WORDS-1:0] diff_mask
);
    logic [DW-1:0] work_d [WORDS];
    logic [DW-1:0] work_q [WORDS];
    logic [DW-1:0] twin_d [WORDS];
    logic [DW-1:0] twin_q [WORDS];

    always_comb begin
        work_d = work_q;
        twin_d = twin_q;
        if (!scan_busy) begin
            if (ld_valid) begin
                work_d[ld_idx] = ld_data;
                twin_d[ld_idx] = ld_data;
            end
            if (wr_valid) begin
                work_d[wr_idx] = wr_data;
            end
        end else if (twin_we) begin
            twin_d[scan_idx] = work_q[scan_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                work_q[i] <= '0;
                twin_q[i] <= '0;
            end
        end else begin
            work_q <= work_d;
            twin_q <= twin_d;
        end
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_cmp
        assign diff_mask[g] = (work_q[g] != twin_q[g]);
    end

    assign scan_data = work_q[scan_idx];

    // R10
    twin_matches_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scan_busy) |-> (diff_mask == '0));
endmodule

// File: rtl/tdw_diff_scan.sv
module tdw_diff_scan #(
    parameter int unsigned WORDS = tdw_pkg::PAGE_WORDS,
    parameter int unsigned DW    = tdw_pkg::WORD_BITS,
    localparam int unsigned IW   = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rel_req,
    input  logic [WORDS-1:0] diff_mask,
    input  logic [DW-1:0]    scan_data,
    output logic [IW-1:0]    scan_idx,
    output logic             twin_we,
    output logic             busy,
    output logic             dv_valid,
    input  logic             dv_ready,
    output logic [IW-1:0]    dv_idx,
    output logic [DW-1:0]    dv_data,
    output logic             dv_last,
    output logic             dv_empty
);
    import tdw_pkg::*;

    typedef struct packed {
        scan_st_e      st;
        logic [IW-1:0] idx;
    } scan_regs_t;

    scan_regs_t r_d, r_q;
    logic [WORDS-1:0] above;
    logic             hit;

    always_comb begin
        r_d      = r_q;
        above    = diff_mask >> ({1'b0, r_q.idx} + (IW+1)'(1));
        hit      = diff_mask[r_q.idx];
        dv_valid = 1'b0;
        dv_idx   = '0;
        dv_data  = '0;
        dv_last  = 1'b0;
        dv_empty = 1'b0;
        twin_we  = 1'b0;
        unique case (r_q.st)
            SC_IDLE: begin
                if (rel_req) begin
                    r_d.idx = '0;
                    r_d.st  = (diff_mask == '0) ? SC_EMPTY : SC_SCAN;
                end
            end
            SC_SCAN: begin
                if (hit) begin
                    dv_valid = 1'b1;
                    dv_idx   = r_q.idx;
                    dv_data  = scan_data;
                    dv_last  = (above == '0);
                    if (dv_ready) begin
                        twin_we = 1'b1;
                        if (above == '0) r_d.st  = SC_IDLE;
                        else             r_d.idx = r_q.idx + 1'b1;
                    end
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end
            SC_EMPTY: begin
                dv_valid = 1'b1;
                dv_last  = 1'b1;
                dv_empty = 1'b1;
                if (dv_ready) r_d.st = SC_IDLE;
            end
            default: r_d.st = SC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: SC_IDLE, idx: '0};
        else        r_q <= r_d;
    end

    assign busy     = (r_q.st != SC_IDLE);
    assign scan_idx = r_q.idx;

    // R8
    beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dv_valid && !dv_ready |=> dv_valid && $stable(dv_idx) && $stable(dv_data)
                                   && $stable(dv_last) && $stable(dv_empty));
    // R4
    ascending_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dv_valid && dv_ready && !dv_last |=> !dv_valid || (dv_idx > $past(dv_idx)));
    // R7
    empty_is_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dv_valid && dv_empty |-> dv_last && (dv_data == '0));
endmodule

// File: rtl/tdw_home_apply.sv
module tdw_home_apply #(
    parameter int unsigned WORDS = tdw_pkg::PAGE_WORDS,
    parameter int unsigned DW    = tdw_pkg::WORD_BITS,
    localparam int unsigned IW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ap_valid,
    input  logic [IW-1:0] ap_idx,
    input  logic [DW-1:0] ap_data,
    input  logic          ap_last,
    input  logic          ap_empty,
    output logic          ap_done,
    input  logic [IW-1:0] hm_idx,
    output logic [DW-1:0] hm_data
);
    logic [DW-1:0] home_d [WORDS];
    logic [DW-1:0] home_q [WORDS];
    logic          done_d, done_q;

    always_comb begin
        home_d = home_q;
        done_d = ap_valid && ap_last;
        if (ap_valid && !ap_empty) home_d[ap_idx] = ap_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) home_q[i] <= '0;
            done_q <= 1'b0;
        end else begin
            home_q <= home_d;
            done_q <= done_d;
        end
    end

    assign ap_done = done_q;
    assign hm_data = home_q[hm_idx];

    // R11
    done_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ap_done |-> $past(ap_valid && ap_last));
    // R11
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ap_valid && ap_last |=> ap_done);
endmodule

// File: rtl/twin_diff_engine.sv
module twin_diff_engine #(
    parameter int unsigned WORDS = tdw_pkg::PAGE_WORDS,
    parameter int unsigned DW    = tdw_pkg::WORD_BITS,
    localparam int unsigned IW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_valid,
    input  logic [IW-1:0] ld_idx,
    input  logic [DW-1:0] ld_data,
    input  logic          wr_valid,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    output logic          wr_ready,
    input  logic          rel_req,
    output logic          rel_busy,
    output logic          dv_valid,
    input  logic          dv_ready,
    output logic [IW-1:0] dv_idx,
    output logic [DW-1:0] dv_data,
    output logic          dv_last,
    output logic          dv_empty,
    input  logic          ap_valid,
    input  logic [IW-1:0] ap_idx,
    input  logic [DW-1:0] ap_data,
    input  logic          ap_last,
    input  logic          ap_empty,
    output logic          ap_done,
    input  logic [IW-1:0] hm_idx,
    output logic [DW-1:0] hm_data
);
    logic             busy;
    logic             twin_we;
    logic [IW-1:0]    scan_idx;
    logic [DW-1:0]    scan_data;
    logic [WORDS-1:0] diff_mask;

    tdw_page_store #(.WORDS(WORDS), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .scan_busy(busy),
        .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_data(ld_data),
        .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_data(wr_data),
        .twin_we(twin_we), .scan_idx(scan_idx), .scan_data(scan_data),
        .diff_mask(diff_mask)
    );

    tdw_diff_scan #(.WORDS(WORDS), .DW(DW)) u_scan (
        .clk(clk), .rst_n(rst_n), .rel_req(rel_req),
        .diff_mask(diff_mask), .scan_data(scan_data), .scan_idx(scan_idx),
        .twin_we(twin_we), .busy(busy),
        .dv_valid(dv_valid), .dv_ready(dv_ready), .dv_idx(dv_idx),
        .dv_data(dv_data), .dv_last(dv_last), .dv_empty(dv_empty)
    );

    tdw_home_apply #(.WORDS(WORDS), .DW(DW)) u_home (
        .clk(clk), .rst_n(rst_n),
        .ap_valid(ap_valid), .ap_idx(ap_idx), .ap_data(ap_data),
        .ap_last(ap_last), .ap_empty(ap_empty), .ap_done(ap_done),
        .hm_idx(hm_idx), .hm_data(hm_data)
    );

    assign rel_busy = busy;
    assign wr_ready = !busy;

    // R9
    stream_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dv_valid |-> !wr_ready);
endmodule

// File: tb/sim_twin_diff_engine.sv
module sim_twin_diff_engine;
    localparam int W = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0, wr_valid = 1'b0, rel_req = 1'b0, dv_ready = 1'b1;
    logic [5:0]  ld_idx = '0, wr_idx = '0, hm_idx = '0;
    logic [31:0] ld_data = '0, wr_data = '0;
    logic        wr_ready, rel_busy, dv_valid, dv_last, dv_empty, ap_done;
    logic [5:0]  dv_idx;
    logic [31:0] dv_data, hm_data;
    logic        sel_b = 1'b0, b_valid = 1'b0, b_last = 1'b0;
    logic [5:0]  b_idx = '0;
    logic [31:0] b_data = '0;
    logic        ap_valid, ap_last, ap_empty;
    logic [5:0]  ap_idx;
    logic [31:0] ap_data;
    logic        toggle_rdy = 1'b0;

    assign ap_valid = sel_b ? b_valid : (dv_valid && dv_ready);
    assign ap_idx   = sel_b ? b_idx   : dv_idx;
    assign ap_data  = sel_b ? b_data  : dv_data;
    assign ap_last  = sel_b ? b_last  : dv_last;
    assign ap_empty = sel_b ? 1'b0    : dv_empty;

    always #4 clk = ~clk;

    twin_diff_engine u0 (.*);

    int compared = 0, mismatched = 0;
    logic [31:0] m_work [W];
    logic [31:0] m_twin [W];
    logic [39:0] exp_q [$];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // beat code: {empty, last, idx[5:0], data[31:0]}
    always begin
        @(negedge clk);
        if (toggle_rdy) dv_ready <= ~dv_ready;
        else            dv_ready <= 1'b1;
    end

    logic        held = 1'b0;
    logic [39:0] held_beat;
    logic        pend_done = 1'b0;
    always begin
        @(negedge clk); #1;
        if (rst_n) begin
            if (held) begin
                chk(dv_valid && {dv_empty, dv_last, dv_idx, dv_data} == held_beat, "R8",
                    {dv_empty, dv_last, dv_idx, dv_data}, held_beat);
            end
            held = dv_valid && !dv_ready;
            held_beat = {dv_empty, dv_last, dv_idx, dv_data};
            if (dv_valid && dv_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 R5 unexpected beat", {dv_empty, dv_last, dv_idx, dv_data}, 0);
                end else begin
                    logic [39:0] e;
                    e = exp_q.pop_front();
                    chk({dv_empty, dv_last, dv_idx, dv_data} == e, "R4 R6 R7 beat",
                        {dv_empty, dv_last, dv_idx, dv_data}, e);
                end
            end
            if (pend_done) chk(ap_done == 1'b1, "R11 done pulse", ap_done, 1);
            else if (ap_done) chk(1'b0, "R11 stray done", ap_done, 0);
            pend_done = ap_valid && ap_last;
        end
    end

    task automatic load_page();
        for (int i = 0; i < W; i++) begin
            @(negedge clk);
            ld_valid = 1'b1; ld_idx = 6'(i); ld_data = 32'h100 + 32'(i) * 3;
            m_work[i] = ld_data; m_twin[i] = ld_data;
        end
        @(negedge clk); ld_valid = 1'b0;
    endtask

    task automatic local_wr(input int i, input logic [31:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_idx = 6'(i); wr_data = d;
        m_work[i] = d;
        @(negedge clk); wr_valid = 1'b0;
    endtask

    task automatic release_page(input bit try_write);
        int last_i;
        last_i = -1;
        for (int i = 0; i < W; i++) if (m_work[i] != m_twin[i]) last_i = i;
        if (last_i < 0) exp_q.push_back({2'b11, 6'd0, 32'd0});
        for (int i = 0; i < W; i++)
            if (m_work[i] != m_twin[i]) exp_q.push_back({1'b0, (i == last_i), 6'(i), m_work[i]});
        for (int i = 0; i < W; i++) m_twin[i] = m_work[i];
        @(negedge clk); rel_req = 1'b1;
        @(negedge clk); rel_req = 1'b0;
        if (try_write) begin
            #2;
            chk(rel_busy == 1'b1 && wr_ready == 1'b0, "R9 refuse during scan", {rel_busy, wr_ready}, 2'b10);
            @(negedge clk);
            wr_valid = 1'b1; wr_idx = 6'd7; wr_data = 32'hDEAD;
            @(negedge clk); wr_valid = 1'b0;
        end
        while (exp_q.size() > 0 || rel_busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send_b(input int i, input logic [31:0] d, input bit last);
        @(negedge clk);
        sel_b = 1'b1; b_valid = 1'b1; b_idx = 6'(i); b_data = d; b_last = last;
        @(negedge clk);
        b_valid = 1'b0; b_last = 1'b0;
    endtask

    task automatic home_chk(input int i, input logic [31:0] e, input string req);
        hm_idx = 6'(i); #1;
        chk(hm_data == e, req, hm_data, e);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1
        chk(wr_ready == 1'b1 && rel_busy == 1'b0 && dv_valid == 1'b0, "R1 reset outputs",
            {wr_ready, rel_busy, dv_valid}, 3'b100);
        home_chk(5, 32'd0, "R1 home zero");
        load_page();
        // R2: load set twin too, so release is empty (R7)
        release_page(1'b0);
        local_wr(10, 32'hAAAA_0001);
        local_wr(3,  32'h0000_0333);
        local_wr(63, 32'hFFFF_0063);
        local_wr(10, 32'hAAAA_0010);
        local_wr(20, m_twin[20]);   // R5: same value as twin
        repeat (5) @(negedge clk);
        #1;
        // R3
        chk(dv_valid == 1'b0, "R3 no beat before release", dv_valid, 0);
        toggle_rdy = 1'b1;
        release_page(1'b1);          // R8, R9, R4, R6
        toggle_rdy = 1'b0;
        // R10 and R9: idx7 write ignored, so next release empty
        release_page(1'b0);
        // R12: second writer, disjoint words
        send_b(5,  32'hB005_0005, 1'b0);
        send_b(40, 32'hB040_0040, 1'b1);
        @(negedge clk); sel_b = 1'b0;
        home_chk(3,  32'h0000_0333, "R11 R12 home A idx3");
        home_chk(10, 32'hAAAA_0010, "R11 R12 home A idx10");
        home_chk(63, 32'hFFFF_0063, "R12 home A idx63");
        home_chk(5,  32'hB005_0005, "R12 home B idx5");
        home_chk(40, 32'hB040_0040, "R12 home B idx40");
        home_chk(4,  32'd0,         "R12 untouched");
        home_chk(7,  32'd0,         "R9 ignored write not sent");
        // R4 boundary indices 0 and 62
        local_wr(62, 32'h6262_6262);
        local_wr(0,  32'h0000_0F00);
        release_page(1'b0);
        home_chk(0,  32'h0000_0F00, "R4 home idx0");
        home_chk(62, 32'h6262_6262, "R4 home idx62");
        chk(exp_q.size() == 0, "R4 all beats seen", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog actual=hang expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule